// File: doc/BRIEF.md
# I2C Controller Interrupt Status, Mask and Clear Unit

This block collects the interrupt sources of an I2C master/slave controller into one interrupt line. FIFO level flags (transmit empty, near-empty and full, and receive empty, near-full and full) pass straight into a raw status word. Transaction events latch there until software clears them. The events are transmit overrun, the two read-from-slave events, the write-to-slave request, master done with stop, slave done, arbitration lost, bus error and master done without stop. A mask word enables individual sources. The masked status is the raw status ANDed with the mask. The interrupt line is high whenever any masked bit is set.

A host reaches the unit through a small register port with a 2-bit select, a write strobe and a combinational read path. Level and event inputs arrive as 32-bit vectors in the positions of the raw word. Only the positions assigned to a source take effect. Completion with stop and completion without stop have separate bits, so a transfer that ends in a repeated start can be told apart from one that releases the bus.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset the mask word reads 0, every event bit of the raw word is 0 and `irq_o` is low.
- R2: Raw bits 0, 1, 2, 4, 5 and 6 equal the same bits of `lvl_i` in the same cycle, with no register in the path.
- R3: Raw event bits 3, 16, 17, 18, 19, 20, 24, 25 and 28 are set by a one-cycle high on the same bit of `evt_i`. They stay set from the next clock edge until they are cleared.
- R4: A write to select 3 clears, at that clock edge, every event bit whose write-data bit is 1. Event bits whose write-data bit is 0 keep their value.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the bit is 1 after the edge.
- R6: Clear writes to bits that are not event bits, including the level bits 0 to 6, change nothing in the raw word. The clearable set is 0x131F007F.
- R7: A write to select 0 loads the mask word from write data. Bits 31:29 always read 0, and the mask changes on no other write.
- R8: Select 2 reads the raw word ANDed with the mask word.
- R9: `irq_o` is the OR of all masked status bits and follows level sources in the same cycle.
- R10: `lvl_i` bits outside the level set and `evt_i` bits outside the event set are ignored. Raw bits 7 to 15, 21 to 23, 26, 27 and 29 to 31 always read 0.
- R11: The select map is 0 = mask (read/write), 1 = raw (read only), 2 = masked (read only), 3 = clear (write only, reads 0). Writes to selects 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_i | input | 32 | FIFO level flags placed at their raw-word positions |
| evt_i | input | 32 | One-cycle event pulses placed at their raw-word positions |
| reg_sel | input | 2 | Register select: 0 mask, 1 raw, 2 masked, 3 clear |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| irq_o | output | 1 | Interrupt request, high while any masked bit is set |

## Verification
On every cycle the assertions check each event bit: it holds while no clear reaches it, a pulse sets it even when a clear arrives in the same cycle, and a clear without a pulse empties it. They also check that the mask stays put without a mask write and that unassigned raw positions stay zero. Several behaviours only show through the bench's scenarios: the exact bit map, level bits ignoring clears, reserved mask bits reading zero, the masked read, the interrupt line tracking a level input combinationally, and writes to read-only selects being dropped.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int unsigned IRQ_W = 32;

   // source placement in the raw word
   localparam logic [IRQ_W-1:0] EVT_MAP_DEF = 32'h131F_0008;
   localparam logic [IRQ_W-1:0] LVL_MAP_DEF = 32'h0000_0077;
   localparam logic [IRQ_W-1:0] CLR_MAP_DEF = 32'h131F_007F;
   localparam logic [IRQ_W-1:0] RSV_MAP_DEF = 32'hE000_0000;

   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_RAW  = 2'd1,
      SEL_MSKD = 2'd2,
      SEL_CLR  = 2'd3
   } irq_sel_e;
endpackage

// File: rtl/irq_raw_bank.sv
module irq_raw_bank #(
   parameter int unsigned          DATA_W  = 32,
   parameter logic [DATA_W-1:0]    EVT_MAP = '0,
   parameter logic [DATA_W-1:0]    LVL_MAP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lvl_i,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] clr_i,
   output logic [DATA_W-1:0] raw_o
);
   logic unused_bits;
   assign unused_bits = ^(lvl_i & ~LVL_MAP) ^ ^(evt_i & ~EVT_MAP) ^ ^(clr_i & ~EVT_MAP);

   if ((EVT_MAP & LVL_MAP) != '0) begin : g_overlap_err
      $error("irq_raw_bank: event and level maps overlap");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (EVT_MAP[i]) begin : g_evt
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag_q <= 1'b0;
            else if (evt_i[i])  flag_q <= 1'b1;
            else if (clr_i[i])  flag_q <= 1'b0;
         end
         assign raw_o[i] = flag_q;

         // R3
         evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (raw_o[i] && !clr_i[i]) |=> raw_o[i]);
         // R5
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> raw_o[i]);
         // R4
         clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !raw_o[i]);
      end else if (LVL_MAP[i]) begin : g_lvl
         assign raw_o[i] = lvl_i[i];
      end else begin : g_none
         assign raw_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned       DATA_W  = 32,
   parameter logic [DATA_W-1:0] RSV_MAP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask_o
);
   logic [DATA_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '0;
      else if (wr_en) mask_q <= wdata & ~RSV_MAP;
   end
   assign mask_o = mask_q;

   // R7
   mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask_o));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import i2c_irq_pkg::*;
#(
   parameter int unsigned       DATA_W  = 32,
   parameter logic [DATA_W-1:0] CLR_MAP = '0
) (
   input  logic [1:0]        sel,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] raw_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              mask_wr_o,
   output logic [DATA_W-1:0] clr_o,
   output logic [DATA_W-1:0] mskd_o,
   output logic [DATA_W-1:0] rdata_o
);
   irq_sel_e sel_e;
   assign sel_e     = irq_sel_e'(sel);
   assign mask_wr_o = wr && (sel_e == SEL_MASK);
   assign clr_o     = (wr && (sel_e == SEL_CLR)) ? (wdata & CLR_MAP) : '0;
   assign mskd_o    = raw_i & mask_i;

   always_comb begin
      unique case (sel_e)
         SEL_MASK: rdata_o = mask_i;
         SEL_RAW:  rdata_o = raw_i;
         SEL_MSKD: rdata_o = mskd_o;
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
   import i2c_irq_pkg::*;
#(
   parameter int unsigned       DATA_W  = IRQ_W,
   parameter logic [DATA_W-1:0] EVT_MAP = EVT_MAP_DEF,
   parameter logic [DATA_W-1:0] LVL_MAP = LVL_MAP_DEF,
   parameter logic [DATA_W-1:0] CLR_MAP = CLR_MAP_DEF,
   parameter logic [DATA_W-1:0] RSV_MAP = RSV_MAP_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] lvl_i,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   localparam logic [DATA_W-1:0] SRC_MAP = EVT_MAP | LVL_MAP;

   if (DATA_W < 29) begin : g_width_err
      $error("i2c_irq_ctrl: DATA_W must hold bit 28");
   end
   if ((EVT_MAP & ~CLR_MAP) != '0) begin : g_clr_err
      $error("i2c_irq_ctrl: every event bit must be clearable");
   end
   if ((SRC_MAP & RSV_MAP) != '0) begin : g_rsv_err
      $error("i2c_irq_ctrl: a source sits on a reserved bit");
   end

   logic [DATA_W-1:0] raw_w, mask_w, clr_w, mskd_w;
   logic              mask_wr_w;

   irq_reg_port #(.DATA_W(DATA_W), .CLR_MAP(CLR_MAP)) port_i (
      .sel(reg_sel), .wr(reg_wr), .wdata(reg_wdata),
      .raw_i(raw_w), .mask_i(mask_w),
      .mask_wr_o(mask_wr_w), .clr_o(clr_w), .mskd_o(mskd_w), .rdata_o(reg_rdata)
   );

   irq_raw_bank #(.DATA_W(DATA_W), .EVT_MAP(EVT_MAP), .LVL_MAP(LVL_MAP)) bank_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .evt_i(evt_i),
      .clr_i(clr_w), .raw_o(raw_w)
   );

   irq_mask_reg #(.DATA_W(DATA_W), .RSV_MAP(RSV_MAP)) mask_i (
      .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_w), .wdata(reg_wdata), .mask_o(mask_w)
   );

   assign irq_o = |mskd_w;

   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_w & ~SRC_MAP) == '0);
endmodule

// File: tb/i2c_irq_ctrl_tb_top.sv
module i2c_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lvl_i = '0;
   logic [31:0] evt_i = '0;
   logic [1:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2c_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .evt_i(evt_i),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(input logic [1:0] sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk);
      evt_i = v;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_read(2'd0, d); check("R1 mask", d, 32'h0);
      reg_read(2'd1, d); check("R1 raw", d, 32'h0);
      check("R1 irq", {31'b0, irq_o}, 32'h0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      lvl_i = 32'h0000_007F;
      reg_read(2'd1, d); check("R2 R10 level bits", d, 32'h0000_0077);
      reg_write(2'd3, 32'h0000_007F);
      reg_read(2'd1, d); check("R6 clear on level bits", d, 32'h0000_0077);
      lvl_i = 32'h0000_0022;
      reg_read(2'd1, d); check("R2 level follows", d, 32'h0000_0022);
      lvl_i = '0;
   endtask

   task automatic t_event();
      logic [31:0] d;
      pulse(32'h131F_0008);
      repeat (2) @(negedge clk);
      reg_read(2'd1, d); check("R3 events latched", d, 32'h131F_0008);
      pulse(32'hEC00_FFF0);
      reg_read(2'd1, d); check("R10 unmapped pulses", d, 32'h131F_0008);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      reg_write(2'd3, 32'h0100_0008);
      reg_read(2'd1, d); check("R4 partial clear", d, 32'h121F_0000);
      reg_write(2'd3, 32'h0CE0_FF00);
      reg_read(2'd1, d); check("R6 clear outside map", d, 32'h121F_0000);
      reg_write(2'd1, 32'h0);
      reg_read(2'd1, d); check("R11 raw write ignored", d, 32'h121F_0000);
      reg_write(2'd2, 32'hFFFF_FFFF);
      reg_read(2'd0, d); check("R11 masked write ignored", d, 32'h0);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      @(negedge clk);
      evt_i = 32'h0100_0000;
      reg_sel = 2'd3; reg_wdata = 32'h0100_0000; reg_wr = 1'b1;
      @(negedge clk);
      evt_i = '0; reg_wr = 1'b0; reg_wdata = '0;
      reg_read(2'd1, d); check("R5 set beats clear", d, 32'h131F_0000);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      reg_write(2'd0, 32'hFFFF_FFFF);
      reg_read(2'd0, d); check("R7 reserved mask bits", d, 32'h1FFF_FFFF);
      reg_read(2'd2, d); check("R8 masked all", d, 32'h131F_0000);
      check("R9 irq high", {31'b0, irq_o}, 32'h1);
      reg_write(2'd0, 32'h0000_0001);
      reg_read(2'd2, d); check("R8 masked none", d, 32'h0);
      check("R9 irq low", {31'b0, irq_o}, 32'h0);
      lvl_i = 32'h0000_0001;
      #1;
      check("R9 irq follows level", {31'b0, irq_o}, 32'h1);
      reg_read(2'd2, d); check("R8 masked level", d, 32'h0000_0001);
      lvl_i = '0;
      reg_read(2'd3, d); check("R11 clear reads zero", d, 32'h0);
      reg_write(2'd0, 32'h0200_0000);
      reg_read(2'd2, d); check("R8 masked bus error", d, 32'h0200_0000);
      reg_write(2'd3, 32'hFFFF_FFFF);
      reg_read(2'd1, d); check("R4 clear all", d, 32'h0);
      check("R9 irq after clear", {31'b0, irq_o}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_level();
      t_event();
      t_clear();
      t_set_wins();
      t_mask();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule